// File: doc/BRIEF.md
# Serial Register-Access Slave with Address Streaming

This block is a four-wire serial slave that gives an external master read and write access to a 128-entry, 8-bit register file. A register address is seven bits wide. Its upper three bits come from a latch that a short set-up transaction loads and that keeps its value across later transactions. A second kind of transaction carries the lower four address bits, a direction bit, a size code and then the data bytes. Single-byte and two-byte transfers are supported, as well as two streaming forms. One stream keeps incrementing the address until chip select goes high. The other cycles over a window of (range + 1) registers that starts at the given address.

The serial interface uses SPI mode 0, MSB first. The master drives data in before each rising edge of the serial clock, and the slave updates its output on each falling edge. The serial pins are sampled by the block clock, which must be fast enough that every serial-clock level lasts at least two block-clock cycles. The stream type and range live in one ordinary register of the map. Each written byte and each completed read byte is announced to the surrounding logic with a one-cycle strobe that carries the address.

Top module: `spi_regfile_slave`

## Requirements
- R1: Serial timing is mode 0, MSB first. Input is sampled on serial-clock rising edges. `miso` changes only after a falling edge and stays stable while the serial clock is high. `miso_oe` is 1 exactly while `cs_n` is low, and `miso` reads 0 outside read data.
- R2: The byte 0x10 as the first byte of a transaction, followed by a byte whose bits [2:0] give the value, loads the upper-address latch. The latch keeps that value over later transactions. The first byte 0x90 makes the next byte return the latch in bits [2:0], with the upper bits 0.
- R3: Any other first byte with bit 4 = 0 is an access command: bit 7 = read (1) or write (0), bits [6:5] = size, bits [3:0] = lower address. The start address is {latch, lower}. Size 0 transfers 1 byte and size 1 transfers 2 bytes at consecutive addresses. Bytes beyond the size do not write, and when reading they return 0.
- R4: Size 2 is reserved. The whole transaction has no effect: no write, no strobe, and reads return 0.
- R5: Size 3 with the stream-type bit at 0 (normal) increments the address after every byte until `cs_n` rises. The address wraps from 0x7F to 0x00.
- R6: Size 3 with the stream-type bit at 1 (controlled) accesses start, start+1, …, start+range, then returns to start, and repeats. Additions wrap modulo 128. Example: start 0x1C with range 5 repeats 0x1C to 0x21.
- R7: The stream control is the register at address 0x03: bit 7 = stream type, bits [2:0] = range. It is sampled when the access command arrives.
- R8: A stream never changes the upper-address latch. Reading the latch back after a stream returns the value set before the stream.
- R9: If `cs_n` rises in the middle of a byte, that byte is discarded with no write and no strobe.
- R10: Each byte written raises `reg_wr_en` for one clock with `reg_addr`/`reg_wdata`. Each read byte that completes raises `reg_rd_en` for one clock with its `reg_addr`. The two strobes never coincide.
- R11: After reset every register is 0, so streaming defaults to normal mode, and the upper-address latch is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso`; the pad is high-impedance when 0 |
| reg_wr_en | output | 1 | One-cycle strobe for each written byte |
| reg_rd_en | output | 1 | One-cycle strobe for each completed read byte |
| reg_addr | output | 7 | Address of the byte being strobed |
| reg_wdata | output | 8 | Data of the byte being written |

## Verification
The embedded properties assume that `cs_n`, `sclk` and `mosi` are already synchronous to `clk`. They also assume that each serial-clock level lasts at least two clock cycles and that `cs_n` changes only while `sclk` is low, so a byte can never complete in two adjacent cycles. The bench keeps within these limits. It changes every serial pin half a nanosecond before a clock edge and holds each serial-clock level for four clock cycles. It raises or lowers chip select only with the serial clock low and at least four cycles away from any serial edge. The random mix of upper-address loads, fixed-size accesses, streams and stream-control writes is built from whole, legal bytes. Partial bytes appear only in the directed abort case.

// File: rtl/spi_rf_pkg.sv
`timescale 1ns/1ps
package spi_rf_pkg;

    typedef enum logic [2:0] {
        ST_INSTR,
        ST_UPPER,
        ST_URA_RD,
        ST_DATA,
        ST_SKIP
    } seq_state_e;

    localparam logic [7:0] OP_SET_UPPER = 8'h10;
    localparam logic [7:0] OP_GET_UPPER = 8'h90;

    localparam logic [1:0] SZ_ONE    = 2'd0;
    localparam logic [1:0] SZ_TWO    = 2'd1;
    localparam logic [1:0] SZ_RSVD   = 2'd2;
    localparam logic [1:0] SZ_STREAM = 2'd3;

endpackage

// File: rtl/spi_rf_shift.sv
`timescale 1ns/1ps
module spi_rf_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              miso,
    output logic              miso_oe,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int              CNT_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rx_sh;
        logic              rx_valid;
        logic [DATA_W-1:0] tx_sh;
        logic              miso;
    } shift_t;

    shift_t s_d, s_q;
    logic   rise, fall;

    always_comb begin
        rise          = sclk & ~s_q.sclk_prev;
        fall          = ~sclk & s_q.sclk_prev;
        s_d           = s_q;
        s_d.sclk_prev = sclk;
        s_d.rx_valid  = 1'b0;
        if (cs_n) begin
            s_d.cnt   = '0;
            s_d.tx_sh = '0;
            s_d.miso  = 1'b0;
        end else if (rise) begin
            s_d.rx_sh = {s_q.rx_sh[DATA_W-2:0], mosi};
            if (s_q.cnt == LAST_BIT) begin
                s_d.cnt      = '0;
                s_d.rx_valid = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (fall) begin
            if (s_q.cnt == '0) begin
                s_d.miso  = tx_byte[DATA_W-1];
                s_d.tx_sh = {tx_byte[DATA_W-2:0], 1'b0};
            end else begin
                s_d.miso  = s_q.tx_sh[DATA_W-1];
                s_d.tx_sh = {s_q.tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign miso     = s_q.miso;
    assign miso_oe  = ~cs_n;
    assign rx_valid = s_q.rx_valid;
    assign rx_byte  = s_q.rx_sh;

    // R1: output bit moves only on a detected falling edge
    a_r1_miso_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !cs_n) |=> $stable(s_q.miso));

    // R9: no byte completes while the slave is deselected
    a_r9_idle_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !s_q.rx_valid);

endmodule

// File: rtl/spi_rf_mem.sv
`timescale 1ns/1ps
module spi_rf_mem #(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int RANGE_W   = 3,
    parameter int CTRL_ADDR = 3,
    parameter int TYPE_BIT  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]  raddr,
    output logic [DATA_W-1:0]  rdata,
    output logic               ctrl_type,
    output logic [RANGE_W-1:0] ctrl_range
);
    localparam int DEPTH = 2 ** ADDR_W;

    typedef logic [DATA_W-1:0] word_t;

    word_t [DEPTH-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata      = mem_q[raddr];
    assign ctrl_type  = mem_q[CTRL_ADDR][TYPE_BIT];
    assign ctrl_range = mem_q[CTRL_ADDR][RANGE_W-1:0];

    // R7: a write to the control entry reaches the stream settings next cycle
    a_r7_ctrl_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == ADDR_W'(CTRL_ADDR)) |=>
            (ctrl_type == $past(wdata[TYPE_BIT]) &&
             ctrl_range == $past(wdata[RANGE_W-1:0])));

endmodule

// File: rtl/spi_rf_seq.sv
`timescale 1ns/1ps
module spi_rf_seq
    import spi_rf_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int UA_W    = 3,
    parameter int DATA_W  = 8,
    parameter int RANGE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               rx_valid,
    input  logic [DATA_W-1:0]  rx_byte,
    input  logic               ctrl_type,
    input  logic [RANGE_W-1:0] ctrl_range,
    input  logic [DATA_W-1:0]  rd_data,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  tx_byte,
    output logic               wr_en,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  acc_addr,
    output logic [DATA_W-1:0]  wr_data
);
    localparam int LA_W     = ADDR_W - UA_W;
    localparam int ZERO_BIT = LA_W;
    localparam int SZ_LO    = LA_W + 1;
    localparam int RD_BIT   = LA_W + 3;

    typedef struct packed {
        seq_state_e         state;
        logic [UA_W-1:0]    ura;
        logic [ADDR_W-1:0]  addr;
        logic [ADDR_W-1:0]  start;
        logic               is_rd;
        logic               stream;
        logic               ctrl;
        logic [RANGE_W-1:0] range;
        logic [1:0]         left;
        logic               wr_en;
        logic               rd_en;
        logic [ADDR_W-1:0]  acc_addr;
        logic [DATA_W-1:0]  wr_data;
    } seq_t;

    seq_t              s_d, s_q;
    logic [1:0]        op_sz;
    logic [ADDR_W-1:0] op_addr;
    logic [ADDR_W-1:0] win_off;

    function automatic logic [ADDR_W-1:0] step_addr(
        input logic [ADDR_W-1:0]  cur,
        input logic [ADDR_W-1:0]  first,
        input logic               wrap_win,
        input logic [RANGE_W-1:0] rng
    );
        logic [ADDR_W-1:0] last;
        last = first + ADDR_W'(rng);
        if (wrap_win && cur == last) begin
            return first;
        end
        return cur + 1'b1;
    endfunction

    always_comb begin
        op_sz      = rx_byte[SZ_LO+1:SZ_LO];
        op_addr    = {s_q.ura, rx_byte[LA_W-1:0]};
        s_d        = s_q;
        s_d.wr_en  = 1'b0;
        s_d.rd_en  = 1'b0;
        if (cs_n) begin
            s_d.state = ST_INSTR;
        end else if (rx_valid) begin
            case (s_q.state)
                ST_INSTR: begin
                    if (rx_byte == OP_SET_UPPER) begin
                        s_d.state = ST_UPPER;
                    end else if (rx_byte == OP_GET_UPPER) begin
                        s_d.state = ST_URA_RD;
                    end else if (!rx_byte[ZERO_BIT]) begin
                        s_d.is_rd  = rx_byte[RD_BIT];
                        s_d.addr   = op_addr;
                        s_d.start  = op_addr;
                        s_d.stream = (op_sz == SZ_STREAM);
                        s_d.ctrl   = (op_sz == SZ_STREAM) && ctrl_type;
                        s_d.range  = ctrl_range;
                        s_d.left   = (op_sz == SZ_ONE) ? 2'd1 : 2'd2;
                        s_d.state  = (op_sz == SZ_RSVD) ? ST_SKIP : ST_DATA;
                    end else begin
                        s_d.state = ST_SKIP;
                    end
                end
                ST_UPPER: begin
                    s_d.ura   = rx_byte[UA_W-1:0];
                    s_d.state = ST_SKIP;
                end
                ST_URA_RD: begin
                    s_d.state = ST_SKIP;
                end
                ST_DATA: begin
                    s_d.acc_addr = s_q.addr;
                    if (s_q.is_rd) begin
                        s_d.rd_en = 1'b1;
                    end else begin
                        s_d.wr_en   = 1'b1;
                        s_d.wr_data = rx_byte;
                    end
                    s_d.addr = step_addr(s_q.addr, s_q.start, s_q.ctrl, s_q.range);
                    if (!s_q.stream) begin
                        s_d.left = s_q.left - 1'b1;
                        if (s_q.left == 2'd1) begin
                            s_d.state = ST_SKIP;
                        end
                    end
                end
                default: begin
                    s_d.state = ST_SKIP;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_INSTR;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (s_q.state == ST_DATA && s_q.is_rd) begin
            tx_byte = rd_data;
        end else if (s_q.state == ST_URA_RD) begin
            tx_byte = {{(DATA_W-UA_W){1'b0}}, s_q.ura};
        end else begin
            tx_byte = '0;
        end
    end

    assign rd_addr  = s_q.addr;
    assign wr_en    = s_q.wr_en;
    assign rd_en    = s_q.rd_en;
    assign acc_addr = s_q.acc_addr;
    assign wr_data  = s_q.wr_data;
    assign win_off  = s_q.addr - s_q.start;

    // R10: strobes are single-cycle and never together
    a_r10_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wr_en |=> !s_q.wr_en);
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_q.wr_en, s_q.rd_en}));

    // R4: a skipped transaction produces no access
    a_r4_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_SKIP) |=> (!s_q.wr_en && !s_q.rd_en));

    // R6: a controlled stream stays inside its window
    a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_DATA && s_q.ctrl) |-> (win_off <= ADDR_W'(s_q.range)));

    // R5: a normal stream advances by one per byte
    a_r5_normal_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.wr_en || s_q.rd_en) && s_q.stream && !s_q.ctrl) |->
            (s_q.addr == s_q.acc_addr + 1'b1));

    // R8: data transfer leaves the upper-address latch alone
    a_r8_ura_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_DATA) |=> $stable(s_q.ura));

endmodule

// File: rtl/spi_regfile_slave.sv
`timescale 1ns/1ps
module spi_regfile_slave #(
    parameter int ADDR_W    = 7,
    parameter int UA_W      = 3,
    parameter int DATA_W    = 8,
    parameter int RANGE_W   = 3,
    parameter int CTRL_ADDR = 3,
    parameter int TYPE_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata
);
    logic               rx_valid;
    logic [DATA_W-1:0]  rx_byte;
    logic [DATA_W-1:0]  tx_byte;
    logic [DATA_W-1:0]  rd_data;
    logic [ADDR_W-1:0]  rd_addr;
    logic               ctrl_type;
    logic [RANGE_W-1:0] ctrl_range;

    spi_rf_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .mosi     (mosi),
        .tx_byte  (tx_byte),
        .miso     (miso),
        .miso_oe  (miso_oe),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte)
    );

    spi_rf_seq #(
        .ADDR_W  (ADDR_W),
        .UA_W    (UA_W),
        .DATA_W  (DATA_W),
        .RANGE_W (RANGE_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .ctrl_type  (ctrl_type),
        .ctrl_range (ctrl_range),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .tx_byte    (tx_byte),
        .wr_en      (reg_wr_en),
        .rd_en      (reg_rd_en),
        .acc_addr   (reg_addr),
        .wr_data    (reg_wdata)
    );

    spi_rf_mem #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .RANGE_W   (RANGE_W),
        .CTRL_ADDR (CTRL_ADDR),
        .TYPE_BIT  (TYPE_BIT)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_wr_en),
        .waddr      (reg_addr),
        .wdata      (reg_wdata),
        .raddr      (rd_addr),
        .rdata      (rd_data),
        .ctrl_type  (ctrl_type),
        .ctrl_range (ctrl_range)
    );

endmodule

// File: tb/tb_spi_regfile_slave.sv
`timescale 1ns/1ps
module tb_spi_regfile_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       miso, miso_oe, reg_wr_en, reg_rd_en;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;

    int         n_chk = 0;
    int         n_fail = 0;
    int         wr_cnt = 0;
    int         rd_cnt = 0;
    logic [6:0] last_wa = '0;
    logic [6:0] last_ra = '0;
    logic [7:0] last_wd = '0;
    logic [7:0] mem_m [128];
    logic [2:0] ura_m = '0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    spi_regfile_slave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso),
        .miso_oe   (miso_oe),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata)
    );

    always @(posedge clk) begin
        if (reg_wr_en) begin
            wr_cnt  <= wr_cnt + 1;
            last_wa <= reg_addr;
            last_wd <= reg_wdata;
        end
        if (reg_rd_en) begin
            rd_cnt  <= rd_cnt + 1;
            last_ra <= reg_addr;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] nxt(input logic [6:0] a, input logic [6:0] st,
                                       input bit ctl, input logic [2:0] rng);
        if (ctl && a == st + {4'b0, rng}) return st;
        return a + 7'd1;
    endfunction

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            mosi = tx[i];
            #20;
            sclk  = 1'b1;
            rx[i] = miso;
            #10;
            check("R1 miso stable while sclk high", miso, rx[i]);
            #10;
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        #20;
        check("R1 oe while selected", miso_oe, 1'b1);
    endtask

    task automatic cs_end();
        #20;
        cs_n = 1'b1;
        #40;
        check("R1 oe off when deselected", miso_oe, 1'b0);
    endtask

    task automatic set_ura(input logic [2:0] u);
        logic [7:0] rx;
        cs_begin();
        xfer(8'h10, rx);
        xfer({5'b10101, u}, rx);
        cs_end();
        ura_m = u;
    endtask

    task automatic read_ura(input string req);
        logic [7:0] rx;
        cs_begin();
        xfer(8'h90, rx);
        xfer(8'h00, rx);
        cs_end();
        check(req, rx, {5'b0, ura_m});
    endtask

    task automatic access(input bit rd, input logic [1:0] sz, input logic [3:0] lra,
                          input int nbytes, input bit fix_en, input logic [7:0] fix_val,
                          input string req);
        logic [6:0] a, st;
        bit         ctl;
        logic [2:0] rng;
        int         lim, w0, r0;
        logic [7:0] rx, wd;
        st  = {ura_m, lra};
        a   = st;
        ctl = (sz == 2'd3) && mem_m[3][7];
        rng = mem_m[3][2:0];
        lim = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd3) ? nbytes : 0;
        cs_begin();
        xfer({rd, sz, 1'b0, lra}, rx);
        for (int i = 0; i < nbytes; i++) begin
            wd = fix_en ? fix_val + 8'(i) : 8'($urandom);
            w0 = wr_cnt;
            r0 = rd_cnt;
            xfer(rd ? 8'h00 : wd, rx);
            if (i < lim) begin
                if (rd) begin
                    check({req, " read data"}, rx, mem_m[a]);
                    check("R10 read strobe count", rd_cnt, r0 + 1);
                    check("R10 read strobe addr", last_ra, a);
                end else begin
                    mem_m[a] = wd;
                    check("R10 write strobe count", wr_cnt, w0 + 1);
                    check({req, " write addr"}, last_wa, a);
                    check("R10 write strobe data", last_wd, wd);
                end
                a = nxt(a, st, ctl, rng);
            end else if (rd) begin
                check({req, " read past size gives 0"}, rx, 8'h00);
            end else begin
                check({req, " no write past size"}, wr_cnt, w0);
            end
        end
        cs_end();
    endtask

    task automatic set_stream(input bit ctl, input logic [2:0] rng);
        logic [2:0] keep;
        keep = ura_m;
        set_ura(3'd0);
        access(1'b0, 2'd0, 4'h3, 1, 1'b1, {ctl, 4'b0, rng}, "R7 control write");
        set_ura(keep);
    endtask

    initial begin
        logic [7:0] rx;
        int         w0;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 128; i++) mem_m[i] = '0;
        #22;
        check("R11 no write strobe in reset", reg_wr_en, 1'b0);
        rst_n = 1'b1;
        #40;
        check("R1 oe off after reset", miso_oe, 1'b0);
        check("R10 no read strobe after reset", reg_rd_en, 1'b0);
        read_ura("R11 latch reset value");
        access(1'b1, 2'd0, 4'h0, 1, 1'b0, 8'h00, "R11 reset register 0x00");
        access(1'b1, 2'd0, 4'h3, 1, 1'b0, 8'h00, "R11 reset stream control");

        // R2 latch persists across transactions
        set_ura(3'd3);
        access(1'b0, 2'd0, 4'hA, 1, 1'b1, 8'h5C, "R2 write 0x3A");
        check("R2 address 0x3A", last_wa, 7'h3A);
        access(1'b1, 2'd1, 4'hA, 2, 1'b0, 8'h00, "R3 two-byte read");
        read_ura("R2 latch readback");

        // R3 bytes past size
        access(1'b0, 2'd1, 4'h4, 4, 1'b1, 8'hA0, "R3 two-byte write");
        access(1'b1, 2'd0, 4'h4, 3, 1'b0, 8'h00, "R3 one-byte read");

        // R4 reserved size
        access(1'b0, 2'd2, 4'h4, 2, 1'b1, 8'hEE, "R4 reserved write");
        access(1'b1, 2'd2, 4'h4, 2, 1'b0, 8'h00, "R4 reserved read");
        access(1'b1, 2'd1, 4'h4, 2, 1'b0, 8'h00, "R4 contents kept");

        // R5 normal stream wraps past 0x7F
        set_ura(3'd7);
        access(1'b0, 2'd3, 4'hE, 4, 1'b1, 8'h11, "R5 normal stream");
        check("R5 last address wrapped", last_wa, 7'h01);
        read_ura("R8 latch after stream");
        access(1'b1, 2'd3, 4'hE, 4, 1'b0, 8'h00, "R5 normal stream read");

        // R6 controlled window
        set_stream(1'b1, 3'd5);
        set_ura(3'd1);
        access(1'b0, 2'd3, 4'hC, 10, 1'b1, 8'h40, "R6 controlled window");
        check("R6 tenth byte address", last_wa, 7'h1F);
        access(1'b1, 2'd0, 4'hC, 1, 1'b0, 8'h00, "R6 start rewritten");
        check("R6 start value", mem_m[7'h1C], 8'h46);
        set_stream(1'b1, 3'd3);
        set_ura(3'd7);
        access(1'b0, 2'd3, 4'hE, 5, 1'b1, 8'h70, "R6 window across 0x7F");
        check("R6 returned to start", last_wa, 7'h7E);
        access(1'b1, 2'd3, 4'hE, 6, 1'b0, 8'h00, "R6 controlled read");
        read_ura("R8 latch after controlled stream");
        set_stream(1'b0, 3'd0);

        // R9 abort mid-byte
        set_ura(3'd2);
        w0 = wr_cnt;
        cs_begin();
        xfer(8'h65, rx);
        xfer_bits(8'hFF, 5, rx);
        #20;
        cs_n = 1'b1;
        #40;
        check("R9 no write on aborted byte", wr_cnt, w0);
        access(1'b1, 2'd0, 4'h5, 1, 1'b0, 8'h00, "R9 register unchanged");

        // random mix
        for (int k = 0; k < 60; k++) begin
            int         op;
            logic [1:0] sz;
            op = $urandom_range(0, 5);
            sz = 2'($urandom_range(0, 1));
            case (op)
                0: set_ura(3'($urandom));
                1: access(1'b0, sz, 4'($urandom), int'(sz) + 1 + $urandom_range(0, 1),
                          1'b0, 8'h00, "R3 random write");
                2: access(1'b1, sz, 4'($urandom), int'(sz) + 1 + $urandom_range(0, 1),
                          1'b0, 8'h00, "R3 random read");
                3: access(1'($urandom), 2'd3, 4'($urandom), $urandom_range(1, 12),
                          1'b0, 8'h00, "R5 random stream");
                4: set_stream(1'($urandom), 3'($urandom));
                default: read_ura("R2 random latch read");
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule